// File: doc/BRIEF.md
# Palette Host Register Port

This block is the processor-facing register port of a color lookup palette. A host accesses it through a byte-wide bus with an active-low chip enable, a 3-bit mode select and a read/not-write strobe. Mode and direction are captured once per enable cycle, on the clock where the enable is first seen low. The port holds a 13-bit palette address, split over a low and a high register. It also holds a command register, a status register, a color buffer readback and a fixed revision value.

Palette data travels one byte at a time. A modulo-3 sequencer steps red, then green, then blue. Red and green writes are parked in a color buffer. The blue write hands the complete 24-bit entry and its address downstream as a one-cycle push strobe, and the address then advances. Palette reads work the same way against a combinational palette read port, but only after a mode-111 access has switched the port into read mode. A second mode-111 access switches it back.

The sequencer has the states C_RED, C_GREEN and C_BLUE. Each palette step moves C_RED→C_GREEN, C_GREEN→C_BLUE or C_BLUE→C_RED, and any address-register write forces a return to C_RED. The access-mode machine has the states PM_WRITE and PM_READ, and each mode-111 access toggles between them (PM_WRITE→PM_READ, PM_READ→PM_WRITE).

Top module: `palette_host_port`

## Requirements
- R1: An access happens only on the first clock where `cs_n` is low after being high. `mode_sel`, `rd_nwr` and `wdata` are used from that clock only, and holding `cs_n` low or changing inputs while it stays low causes no further access.
- R2: Mode 000 writes and reads address bits 7:0. Mode 001 writes address bits 12:8 from `wdata[4:0]`, and a read of it returns those 5 bits with bits 7:5 read as zero.
- R3: A write to mode 000 or 001 returns the sequencer to red, so that the next palette byte is taken as red.
- R4: Palette writes (mode 010) take red, green and blue in that order. The blue write raises `push_valid` for exactly one cycle, with `push_addr` equal to the address before increment and `push_color` = {red[23:16], green[15:8], blue[7:0]}.
- R5: The address increments by one only after a blue palette access, and it wraps from 0x1FFF to 0x0000.
- R6: Red and green palette writes are kept in a color buffer, and an incomplete triplet produces no push. After an address write, two successive mode-101 reads return red and then green.
- R7: A mode-111 access toggles between normal and read mode. In read mode, palette reads return bits 23:16, 15:8 and 7:0 of `pal_rd_data` for `pal_rd_addr` (the current address) in turn, and the address increments after the third read. In normal mode, palette reads return zero and do not advance the sequencer.
- R8: Mode 011 is a read/write command register whose value drives `cmd_q`, and it changes only on a mode-011 write.
- R9: Mode 100 reads status as {5'b0, read-mode flag, sequencer[1:0]}, with sequencer codes 00 red, 01 green and 10 blue. Mode 110 reads the revision parameter. Writes to modes 100, 101 and 110 change nothing, and a read of mode 111 returns zero.
- R10: After reset, the address, command, `rdata`, `push_valid` and status are all zero, which means the sequencer is at red and normal mode is active.
- R11: `rdata` changes only on read accesses and holds its value across write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip enable; its falling edge starts an access |
| mode_sel | input | 3 | Register/mode select |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, held until the next read |
| cmd_q | output | 8 | Command register contents |
| pal_rd_addr | output | 13 | Palette address for readback |
| pal_rd_data | input | 24 | Palette entry at `pal_rd_addr` |
| push_valid | output | 1 | One-cycle strobe for a completed entry |
| push_addr | output | 13 | Address of the pushed entry |
| push_color | output | 24 | Color of the pushed entry |

## Verification
Palette writes are tried as a complete triplet, as a triplet whose address sits at the top of the range, as a red-green pair with no blue, and as a red byte cut off by an address write. These cases separate correct byte ordering, address wrap, the absence of a push on a partial entry and the sequencer clear. Palette reads are made both outside and inside read mode, which shows whether the mode toggle gates both the data and the sequencer. An enable held low while its inputs change shows whether an access fires only on the falling edge.

// File: rtl/php_pkg.sv
package php_pkg;
    typedef enum logic [1:0] {
        C_RED   = 2'd0,
        C_GREEN = 2'd1,
        C_BLUE  = 2'd2
    } color_e;

    typedef enum logic [2:0] {
        M_ADDR_LO = 3'd0,
        M_ADDR_HI = 3'd1,
        M_PAL     = 3'd2,
        M_CMD     = 3'd3,
        M_STATUS  = 3'd4,
        M_CBUF    = 3'd5,
        M_REV     = 3'd6,
        M_RDINIT  = 3'd7
    } mode_e;

    typedef enum logic {
        PM_WRITE = 1'b0,
        PM_READ  = 1'b1
    } pmode_e;
endpackage

// File: rtl/php_cs_edge.sv
module php_cs_edge
    import php_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [2:0] mode_in,
    input  logic       rnw_in,
    output logic       acc,
    output mode_e      mode,
    output logic       rnw
);
    logic cs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    always_comb begin
        acc  = cs_q & ~cs_n;
        mode = mode_e'(mode_in);
        rnw  = rnw_in;
    end

    // R1: an enable cycle yields a single access
    assert_single_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !acc);
endmodule

// File: rtl/php_rgb_seq.sv
module php_rgb_seq
    import php_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   step,
    output color_e sel,
    output logic   last
);
    color_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C_RED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = C_RED;
        end else if (step) begin
            unique case (state_q)
                C_RED:   state_d = C_GREEN;
                C_GREEN: state_d = C_BLUE;
                C_BLUE:  state_d = C_RED;
                default: state_d = C_RED;
            endcase
        end
    end

    always_comb begin
        sel  = state_q;
        last = (state_q == C_BLUE);
    end

    assert_clear_to_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sel == C_RED));
    assert_blue_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && last) |=> (sel == C_RED));
endmodule

// File: rtl/palette_host_port.sv
module palette_host_port
    import php_pkg::*;
#(
    parameter int          ADDR_W = 13,
    parameter int          BYTE_W = 8,
    parameter logic [7:0]  REV_ID = 8'h11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic [2:0]          mode_sel,
    input  logic                rd_nwr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    output logic [BYTE_W-1:0]   cmd_q,
    output logic [ADDR_W-1:0]   pal_rd_addr,
    input  logic [3*BYTE_W-1:0] pal_rd_data,
    output logic                push_valid,
    output logic [ADDR_W-1:0]   push_addr,
    output logic [3*BYTE_W-1:0] push_color
);
    localparam int COLOR_W = 3 * BYTE_W;
    localparam int HI_W    = ADDR_W - BYTE_W;

    logic   acc, rnw;
    mode_e  mode;
    color_e seq;
    logic   seq_last;
    pmode_e pm_q, pm_d;

    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] buf_r, buf_g;
    logic              cbuf_sel;
    logic [BYTE_W-1:0] rd_mux, pal_byte;

    logic acc_wr, acc_rd, wr_lo, wr_hi, addr_wr, pal_wr, pal_rd_ok, seq_step, pm_toggle;

    php_cs_edge u_edge (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_in(mode_sel), .rnw_in(rd_nwr),
        .acc(acc), .mode(mode), .rnw(rnw)
    );

    php_rgb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .clr(addr_wr), .step(seq_step),
        .sel(seq), .last(seq_last)
    );

    always_comb begin
        acc_wr    = acc & ~rnw;
        acc_rd    = acc & rnw;
        wr_lo     = acc_wr & (mode == M_ADDR_LO);
        wr_hi     = acc_wr & (mode == M_ADDR_HI);
        addr_wr   = wr_lo | wr_hi;
        pal_wr    = acc_wr & (mode == M_PAL);
        pal_rd_ok = acc_rd & (mode == M_PAL) & (pm_q == PM_READ);
        seq_step  = pal_wr | pal_rd_ok;
        pm_toggle = acc & (mode == M_RDINIT);
    end

    // access-mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) pm_q <= PM_WRITE;
        else        pm_q <= pm_d;
    end

    always_comb begin
        pm_d = pm_q;
        unique case (pm_q)
            PM_WRITE: if (pm_toggle) pm_d = PM_READ;
            PM_READ:  if (pm_toggle) pm_d = PM_WRITE;
            default:  pm_d = PM_WRITE;
        endcase
    end

    // palette byte selected by sequencer
    always_comb begin
        unique case (seq)
            C_RED:   pal_byte = pal_rd_data[COLOR_W-1 -: BYTE_W];
            C_GREEN: pal_byte = pal_rd_data[2*BYTE_W-1 -: BYTE_W];
            C_BLUE:  pal_byte = pal_rd_data[BYTE_W-1:0];
            default: pal_byte = '0;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        unique case (mode)
            M_ADDR_LO: rd_mux = addr_q[BYTE_W-1:0];
            M_ADDR_HI: rd_mux[HI_W-1:0] = addr_q[ADDR_W-1:BYTE_W];
            M_PAL:     rd_mux = (pm_q == PM_READ) ? pal_byte : '0;
            M_CMD:     rd_mux = cmd_q;
            M_STATUS: begin
                rd_mux[2]   = (pm_q == PM_READ);
                rd_mux[1:0] = seq;
            end
            M_CBUF:    rd_mux = cbuf_sel ? buf_g : buf_r;
            M_REV:     rd_mux = REV_ID[BYTE_W-1:0];
            M_RDINIT:  rd_mux = '0;
            default:   rd_mux = '0;
        endcase
    end

    // output and register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            cmd_q      <= '0;
            buf_r      <= '0;
            buf_g      <= '0;
            cbuf_sel   <= 1'b0;
            rdata      <= '0;
            push_valid <= 1'b0;
            push_addr  <= '0;
            push_color <= '0;
        end else begin
            push_valid <= pal_wr & seq_last;
            if (pal_wr && seq_last) begin
                push_addr  <= addr_q;
                push_color <= {buf_r, buf_g, wdata};
            end

            if (wr_lo)
                addr_q[BYTE_W-1:0] <= wdata;
            else if (wr_hi)
                addr_q[ADDR_W-1:BYTE_W] <= wdata[HI_W-1:0];
            else if (seq_step && seq_last)
                addr_q <= addr_q + 1'b1;

            if (acc_wr && mode == M_CMD) cmd_q <= wdata;

            if (pal_wr && seq == C_RED)   buf_r <= wdata;
            if (pal_wr && seq == C_GREEN) buf_g <= wdata;

            if (addr_wr)
                cbuf_sel <= 1'b0;
            else if (acc_rd && mode == M_CBUF)
                cbuf_sel <= ~cbuf_sel;

            if (acc_rd) rdata <= rd_mux;
        end
    end

    always_comb pal_rd_addr = addr_q;

    assert_push_on_blue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !rnw && mode == M_PAL && seq == C_BLUE) |=> push_valid);
    assert_push_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == M_PAL && seq == C_BLUE && (!rnw || pm_q == PM_READ))
        |=> (addr_q == $past(addr_q) + 1'b1));
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && rnw) |=> $stable(rdata));
    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && !rnw && mode == M_CMD) |=> $stable(cmd_q));
    assert_no_pal_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rnw && mode == M_PAL && pm_q == PM_WRITE) |=> $stable(seq));
endmodule

// File: tb/tb_palette_host_port.sv
`timescale 1ns/1ps
module tb_palette_host_port;
    localparam logic [7:0] REV = 8'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [2:0]  mode_sel = 3'd0;
    logic        rd_nwr = 1'b1;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata, cmd_q;
    logic [12:0] pal_rd_addr, push_addr;
    logic [23:0] pal_rd_data, push_color;
    logic        push_valid;

    int checks = 0;
    int errors = 0;
    logic [36:0] sb_q[$];

    always #2 clk = ~clk;

    function automatic logic [23:0] ramf(input logic [12:0] a);
        return {a[7:0], 3'b000, a[12:8], a[7:0] ^ 8'h5A};
    endfunction

    assign pal_rd_data = ramf(pal_rd_addr);

    palette_host_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_sel(mode_sel), .rd_nwr(rd_nwr),
        .wdata(wdata), .rdata(rdata), .cmd_q(cmd_q), .pal_rd_addr(pal_rd_addr),
        .pal_rd_data(pal_rd_data), .push_valid(push_valid), .push_addr(push_addr),
        .push_color(push_color)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares every push against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && push_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R4/R6 unexpected push", {19'b0, push_addr}, 32'h0);
            end else begin
                logic [36:0] e;
                e = sb_q.pop_front();
                chk({push_addr, push_color} == e, "R4 push addr/color",
                    {push_addr[7:0], push_color}, {e[31:24], e[23:0]});
            end
        end
    end

    task automatic expect_push(input logic [12:0] a, input logic [23:0] c);
        sb_q.push_back({a, c});
    endtask

    task automatic access(input logic [2:0] m, input logic rnw, input logic [7:0] wd,
                          output logic [7:0] rd);
        @(negedge clk);
        cs_n = 1'b0; mode_sel = m; rd_nwr = rnw; wdata = wd;
        @(negedge clk); #0.5;
        rd = rdata;
        cs_n = 1'b1;
        @(negedge clk); #0.5;
    endtask

    task automatic wr(input logic [2:0] m, input logic [7:0] d);
        logic [7:0] dummy;
        access(m, 1'b0, d, dummy);
    endtask

    task automatic rdchk(input logic [2:0] m, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        access(m, 1'b1, 8'h00, got);
        chk(got == exp, tag, {24'b0, got}, {24'b0, exp});
    endtask

    task automatic drained(input string tag);
        chk(sb_q.size() == 0, tag, sb_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        // R10 reset state
        chk(rdata == 0, "R10 rdata", rdata, 0);
        chk(push_valid == 0, "R10 push_valid", push_valid, 0);
        chk(cmd_q == 0, "R10 cmd", cmd_q, 0);
        chk(pal_rd_addr == 0, "R10 addr", pal_rd_addr, 0);
        rdchk(3'd4, 8'h00, "R10 status");
        rdchk(3'd6, REV, "R9 revision");

        // R2 address registers
        wr(3'd0, 8'h34);
        wr(3'd1, 8'hFF);
        rdchk(3'd1, 8'h1F, "R2 high addr 5 bits");
        rdchk(3'd0, 8'h34, "R2 low addr");

        // R4 full triplet
        wr(3'd2, 8'h11);
        wr(3'd2, 8'h22);
        rdchk(3'd4, 8'h02, "R9 status seq blue");
        expect_push(13'h1F34, 24'h112233);
        wr(3'd2, 8'h33);
        drained("R4 push seen");
        rdchk(3'd0, 8'h35, "R5 addr increment");

        // R5 wrap
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'h1F);
        wr(3'd2, 8'hA1);
        wr(3'd2, 8'hA2);
        expect_push(13'h1FFF, 24'hA1A2A3);
        wr(3'd2, 8'hA3);
        drained("R5 wrap push");
        rdchk(3'd0, 8'h00, "R5 wrap low");
        rdchk(3'd1, 8'h00, "R5 wrap high");

        // R6 partial entry recovery
        wr(3'd2, 8'hAB);
        wr(3'd2, 8'hCD);
        wr(3'd0, 8'h10);
        drained("R6 no push on partial");
        rdchk(3'd5, 8'hAB, "R6 cbuf red");
        rdchk(3'd5, 8'hCD, "R6 cbuf green");
        rdchk(3'd4, 8'h00, "R3 seq red after addr write");

        // R3 address write restarts the triplet
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h20);
        wr(3'd2, 8'h44);
        wr(3'd2, 8'h55);
        expect_push(13'h0020, 24'h445566);
        wr(3'd2, 8'h66);
        drained("R3 restarted triplet");

        // R9 writes to read-only modes ignored
        wr(3'd6, 8'h00);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'h00);
        rdchk(3'd6, REV, "R9 revision unchanged");
        rdchk(3'd4, 8'h00, "R9 status unchanged");
        rdchk(3'd5, 8'h44, "R9 cbuf unchanged");
        rdchk(3'd0, 8'h21, "R9 addr unchanged");

        // R8 command register
        wr(3'd3, 8'h5A);
        chk(cmd_q == 8'h5A, "R8 cmd_q", cmd_q, 8'h5A);
        rdchk(3'd3, 8'h5A, "R8 cmd readback");

        // R11 rdata held across a write
        wr(3'd3, 8'h3C);
        chk(rdata == 8'h5A, "R11 rdata hold", rdata, 8'h5A);
        chk(cmd_q == 8'h3C, "R8 cmd rewrite", cmd_q, 8'h3C);

        // R7 palette read gating
        rdchk(3'd2, 8'h00, "R7 normal-mode palette read zero");
        rdchk(3'd4, 8'h00, "R7 no advance in normal mode");
        wr(3'd7, 8'h00);
        rdchk(3'd4, 8'h04, "R7 read mode flag");
        wr(3'd0, 8'h07);
        wr(3'd1, 8'h01);
        chk(pal_rd_addr == 13'h107, "R7 pal_rd_addr", pal_rd_addr, 13'h107);
        begin
            logic [23:0] e;
            e = ramf(13'h107);
            rdchk(3'd2, e[23:16], "R7 read red");
            rdchk(3'd2, e[15:8], "R7 read green");
            rdchk(3'd2, e[7:0], "R7 read blue");
        end
        drained("R7 no push on reads");
        rdchk(3'd0, 8'h08, "R7 addr increments after read triplet");
        rdchk(3'd7, 8'h00, "R9 mode 111 reads zero");
        rdchk(3'd4, 8'h00, "R7 back to normal");

        // R1 only the falling edge of cs_n starts an access
        @(negedge clk);
        cs_n = 1'b0; mode_sel = 3'd3; rd_nwr = 1'b0; wdata = 8'h77;
        repeat (3) @(negedge clk);
        wdata = 8'h99; mode_sel = 3'd0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk); #0.5;
        chk(cmd_q == 8'h77, "R1 single capture", cmd_q, 8'h77);
        rdchk(3'd0, 8'h08, "R1 no access while held low");

        repeat (3) @(negedge clk);
        drained("R4 scoreboard empty at end");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule